// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block runs the request/acknowledge exchange for one DMA channel and keeps that channel's transfer count. A peripheral raises a request line. The block passes that line through a short flop synchronizer and then opens an atomic transfer by raising its acknowledge output. It keeps acknowledge high while the bus side reports completed beats. An atomic transfer is either one beat or a burst of four, and one bus ownership covers all of it. When the transfer ends, the block decides when another may start. In demand mode it drops acknowledge at once and restarts if the request is still high. In handshake mode it holds acknowledge until the request has been seen low, so each request pulse yields exactly one transfer.

Software writes a 32-bit control word and loads the transfer count. The count falls by one for each finished atomic transfer. When it reaches zero the channel stops acknowledging requests. It can then either raise a one-cycle interrupt or be polled through the exported count. The block does not generate addresses, arbitrate for the bus or move data.

Top module: `dma_req_seq`

## Requirements
- R1: After reset the stored control word is zero, and `dack_o`, `irq_o`, `sync_sel_o` and `count_o` are all 0.
- R2: `dreq_i` reaches the sequencer through a two-stage synchronizer. A request driven before clock edge n raises `dack_o` after edge n+2 and not earlier.
- R3: With control bit 28 = 0 (unit size), one `beat_done_i` strobe while `dack_o` is high completes the atomic transfer.
- R4: With control bit 28 = 1 (burst size), `dack_o` stays high through the first three beat strobes. The transfer completes on the fourth.
- R5: With control bit 31 = 0 (demand), `dack_o` falls in the cycle after the completing beat. If the synchronized request is still high and the count is nonzero, `dack_o` rises again one cycle later.
- R6: With control bit 31 = 1 (handshake), `dack_o` stays high after the completing beat until the synchronized request is low, then falls. No new transfer starts until a new request arrives.
- R7: `cnt_load` sets `count_o` to `cnt_value` on the next edge. Each completed atomic transfer, unit or burst, lowers `count_o` by exactly one.
- R8: While `count_o` is zero no transfer starts, whatever the request line does.
- R9: With control bit 29 = 1, the transfer that brings the count from 1 to 0 makes `irq_o` high for exactly one cycle, in the cycle the count reads 0.
- R10: With control bit 29 = 0, `irq_o` stays low when the count reaches zero.
- R11: Control bit 30 is stored and shown on `sync_sel_o`. It has no other effect.
- R12: A `beat_done_i` strobe while `dack_o` is low changes neither `count_o` nor `dack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word (bit 31 mode, 30 sync select, 29 interrupt enable, 28 size) |
| cnt_load | input | 1 | Load strobe for the transfer count |
| cnt_value | input | CNT_W | Count to load |
| dreq_i | input | 1 | Asynchronous transfer request |
| beat_done_i | input | 1 | Bus side reports one beat finished |
| dack_o | output | 1 | Transfer acknowledge |
| irq_o | output | 1 | Terminal-count interrupt pulse |
| count_o | output | CNT_W | Remaining atomic transfers |
| sync_sel_o | output | 1 | Stored synchronization-select bit |

## Verification
The bench builds the block with CNT_W = 6, BURST_LEN = 4 and SYNC_STAGES = 2. The small count width means the zero boundary, and the single interrupt pulse at that boundary, are reached after only a few transfers. The default burst length and synchronizer depth give a fixed three-edge request latency and a four-beat burst, so the bench can check the exact cycle of every rise and fall of the acknowledge output in both restart policies.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int MODE_BIT = 31;
  localparam int SYNC_BIT = 30;
  localparam int IRQ_BIT  = 29;
  localparam int SIZE_BIT = 28;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_XFER = 2'd1,
    CH_HOLD = 2'd2
  } ch_state_e;

  typedef struct packed {
    logic hs_mode;
    logic sync_sel;
    logic irq_en;
    logic burst;
  } ch_ctrl_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             irq_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, count_d;
  logic             irq_q, irq_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = load_i | dec_i;
    count_d = count_q;
    if (load_i)     count_d = load_val_i;
    else if (dec_i) count_d = count_q - ONE;
    irq_d = dec_i & ~load_i & irq_en_i & (count_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign count_o = count_q;
  assign zero_o  = (count_q == '0);
  assign irq_o   = irq_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !dec_i) |=> $stable(count_q)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && dec_i) |=> (count_q == $past(count_q) - ONE)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R9
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0)); // R9
endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
  import dma_seq_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_s_i,
  input  logic cnt_zero_i,
  input  logic hs_mode_i,
  input  logic burst_i,
  input  logic beat_done_i,
  output logic dack_o,
  output logic xfer_done_o
);
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BW-1:0] LAST_BURST = BW'(BURST_LEN - 1);

  ch_state_e       state_q, state_d;
  logic [BW-1:0]   beat_q, beat_d;
  logic            last_beat;

  always_comb begin
    last_beat   = burst_i ? (beat_q == LAST_BURST) : 1'b1;
    state_d     = state_q;
    beat_d      = beat_q;
    xfer_done_o = 1'b0;
    case (state_q)
      CH_IDLE: begin
        beat_d = '0;
        if (dreq_s_i && !cnt_zero_i) state_d = CH_XFER;
      end
      CH_XFER: begin
        if (beat_done_i) begin
          if (last_beat) begin
            xfer_done_o = 1'b1;
            beat_d      = '0;
            state_d     = hs_mode_i ? CH_HOLD : CH_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      CH_HOLD: begin
        if (!dreq_s_i) state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign dack_o = (state_q == CH_XFER) || (state_q == CH_HOLD);

  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_HOLD && dreq_s_i) |=> (state_q == CH_HOLD)); // R6
  AST_NO_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_IDLE && cnt_zero_i) |=> (state_q == CH_IDLE)); // R8
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [31:0]      ctrl_wdata,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             dreq_i,
  input  logic             beat_done_i,
  output logic             dack_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_o,
  output logic             sync_sel_o
);
  ch_ctrl_t ctrl_q, ctrl_d;
  logic     dreq_s;
  logic     cnt_zero;
  logic     xfer_done;
  logic     unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_wdata[SIZE_BIT-1:0];

  always_comb begin
    ctrl_d.hs_mode  = ctrl_wdata[MODE_BIT];
    ctrl_d.sync_sel = ctrl_wdata[SYNC_BIT];
    ctrl_d.irq_en   = ctrl_wdata[IRQ_BIT];
    ctrl_d.burst    = ctrl_wdata[SIZE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dreq_i),
    .q_o   (dreq_s)
  );

  chan_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreq_s_i    (dreq_s),
    .cnt_zero_i  (cnt_zero),
    .hs_mode_i   (ctrl_q.hs_mode),
    .burst_i     (ctrl_q.burst),
    .beat_done_i (beat_done_i),
    .dack_o      (dack_o),
    .xfer_done_o (xfer_done)
  );

  xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_value),
    .dec_i      (xfer_done),
    .irq_en_i   (ctrl_q.irq_en),
    .count_o    (count_o),
    .zero_o     (cnt_zero),
    .irq_o      (irq_o)
  );

  assign sync_sel_o = ctrl_q.sync_sel;

  AST_DACK_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_o) |-> $past(dreq_i, SYNC_STAGES + 1)); // R2
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !dack_o && !cnt_load) |=> !dack_o); // R8
endmodule

// File: tb/dma_req_seq_bench.sv
module dma_req_seq_bench;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctrl_we = 1'b0;
  logic [31:0]      ctrl_wdata = '0;
  logic             cnt_load = 1'b0;
  logic [CNT_W-1:0] cnt_value = '0;
  logic             dreq_i = 1'b0;
  logic             beat_done_i = 1'b0;
  logic             dack_o, irq_o, sync_sel_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dma_req_seq #(.CNT_W(CNT_W), .BURST_LEN(4), .SYNC_STAGES(2)) u_dma_req_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .dreq_i(dreq_i),
    .beat_done_i(beat_done_i), .dack_o(dack_o), .irq_o(irq_o),
    .count_o(count_o), .sync_sel_o(sync_sel_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input bit hs, input bit sy, input bit ie, input bit bu);
    ctrl_wdata = {hs, sy, ie, bu, 28'h5A5A5A5};
    ctrl_we = 1'b1;
    tick(1);
    ctrl_we = 1'b0;
  endtask

  task automatic load(input int n);
    cnt_value = CNT_W'(n);
    cnt_load = 1'b1;
    tick(1);
    cnt_load = 1'b0;
  endtask

  task automatic beat();
    beat_done_i = 1'b1;
    tick(1);
    beat_done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "dack", dack_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "count", count_o, 0);
    chk("R1", "sync_sel", sync_sel_o, 0);
  endtask

  task automatic t_demand_unit();
    set_ctrl(0, 0, 1, 0);
    load(3);
    chk("R7", "count after load", count_o, 3);
    dreq_i = 1'b1;
    tick(1); chk("R2", "dack after 1 edge", dack_o, 0);
    tick(1); chk("R2", "dack after 2 edges", dack_o, 0);
    tick(1); chk("R2", "dack after 3 edges", dack_o, 1);
    beat();
    chk("R3", "dack after unit beat", dack_o, 0);
    chk("R7", "count after transfer", count_o, 2);
    tick(1); chk("R5", "demand restart", dack_o, 1);
    beat(); chk("R5", "demand drop", dack_o, 0);
    chk("R7", "count", count_o, 1);
    tick(1); chk("R5", "demand restart 2", dack_o, 1);
    beat();
    chk("R7", "count at zero", count_o, 0);
    chk("R9", "irq at zero", irq_o, 1);
    tick(1); chk("R9", "irq one cycle", irq_o, 0);
    chk("R8", "no start at zero", dack_o, 0);
    tick(4); chk("R8", "still idle at zero", dack_o, 0);
    dreq_i = 1'b0;
    tick(3);
  endtask

  task automatic t_ignored_beat();
    load(2);
    beat();
    chk("R12", "count after stray beat", count_o, 2);
    chk("R12", "dack after stray beat", dack_o, 0);
  endtask

  task automatic t_handshake_burst();
    set_ctrl(1, 0, 0, 1);
    load(5);
    dreq_i = 1'b1;
    tick(3); chk("R6", "dack on request", dack_o, 1);
    for (int i = 0; i < 3; i++) begin
      beat();
      chk("R4", "dack mid burst", dack_o, 1);
      chk("R4", "count mid burst", count_o, 5);
    end
    beat();
    chk("R4", "count after burst", count_o, 4);
    chk("R6", "dack held after burst", dack_o, 1);
    tick(5);
    chk("R6", "dack held while req high", dack_o, 1);
    chk("R6", "no second transfer", count_o, 4);
    dreq_i = 1'b0;
    tick(2); chk("R6", "dack before req seen low", dack_o, 1);
    tick(1); chk("R6", "dack drops on req low", dack_o, 0);
    dreq_i = 1'b1;
    tick(3); chk("R6", "fresh request", dack_o, 1);
    for (int i = 0; i < 4; i++) beat();
    chk("R7", "count after second burst", count_o, 3);
    dreq_i = 1'b0;
    tick(3);
    chk("R6", "idle after release", dack_o, 0);
  endtask

  task automatic t_no_irq();
    set_ctrl(1, 0, 0, 0);
    load(1);
    dreq_i = 1'b1;
    tick(3);
    beat();
    chk("R10", "count zero", count_o, 0);
    chk("R10", "no irq", irq_o, 0);
    tick(1); chk("R10", "no irq later", irq_o, 0);
    dreq_i = 1'b0;
    tick(3);
    chk("R6", "dack low after release", dack_o, 0);
  endtask

  task automatic t_demand_burst();
    set_ctrl(0, 0, 1, 1);
    load(1);
    dreq_i = 1'b1;
    tick(3);
    for (int i = 0; i < 3; i++) begin
      beat();
      chk("R4", "demand burst dack", dack_o, 1);
    end
    beat();
    chk("R4", "demand burst end", dack_o, 0);
    chk("R9", "irq after burst", irq_o, 1);
    chk("R7", "count", count_o, 0);
    dreq_i = 1'b0;
    tick(3);
  endtask

  task automatic t_sync_sel();
    set_ctrl(0, 1, 0, 0);
    chk("R11", "sync_sel set", sync_sel_o, 1);
    chk("R11", "dack unaffected", dack_o, 0);
    set_ctrl(0, 0, 0, 0);
    chk("R11", "sync_sel clear", sync_sel_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_demand_unit();
    t_ignored_beat();
    t_handshake_burst();
    t_no_irq();
    t_demand_burst();
    t_sync_sel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule